// File: doc/BRIEF.md
# Track Command Packet Framer

This block assembles one track command packet and streams it out one bit per handshake to a downstream consumer, typically a chip-rate spreader that expands each bit into a spreading sequence. A single-cycle start request captures an engine number and a command payload. The block then offers the packet bits in order over a valid/ready pair. A busy flag covers the whole packet. A one-cycle done pulse marks the end.

The packet opens with a long run of ones, so that the coupling network on the track settles before the body arrives. A lone zero then marks the start of the body. The address follows, and it carries the engine number plus one with the least significant bit first. After the address come a one, the command bits with the most significant bit first, and a closing run of ones. The lengths of both runs of ones and the width of the command are parameters. With the defaults, a packet is 64 bits long.

Top module: `pkt_framer`

## Requirements
- R1: During and right after reset, `busy_o`, `bit_valid_o` and `done_o` are all 0.
- R2: A `start_i` pulse while idle makes `busy_o` and `bit_valid_o` go to 1 on the next cycle. The engine and command values are captured on that edge, so later changes on those inputs do not affect the packet.
- R3: The first `LEAD_LEN` bits accepted (default 15) are all 1.
- R4: Exactly one 0 bit follows the leading ones.
- R5: The next 8 bits are (engine number + 1) mod 256, sent bit 0 first. For example, engine 49 gives 0,1,0,0,1,1,0,0.
- R6: After the address comes one 1 bit. Then the `CMD_W` command bits follow, starting at index `CMD_W-1` and ending at index 0.
- R7: The packet ends with `TAIL_LEN` ones (default 10), for a total of `LEAD_LEN+TAIL_LEN+CMD_W+10` accepted bits. With engine 49 and command 29'b01000000000000001000000011000, the whole packet reads 1111111111111110010011001010000000000000010000000110001111111111.
- R8: While `bit_valid_o` is 1 and `bit_ready_i` is 0, the next cycle still has `bit_valid_o` at 1 and the same `bit_o`.
- R9: `start_i` has no effect while `busy_o` is 1. The packet in flight continues unchanged.
- R10: `done_o` is 1 for exactly one cycle, namely the cycle after the last trailing one is accepted. In that cycle `busy_o` and `bit_valid_o` are already 0.
- R11: Engine number 255 wraps to an address field of all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to build and send one packet |
| engine_i | input | ADDR_W | Engine number (the block adds one) |
| cmd_i | input | CMD_W | Command payload |
| bit_valid_o | output | 1 | A packet bit is offered |
| bit_ready_i | input | 1 | Downstream accepts the offered bit |
| bit_o | output | 1 | Offered packet bit |
| busy_o | output | 1 | A packet is in progress |
| done_o | output | 1 | One-cycle pulse after the final bit is accepted |

## Verification
A phase counter that slips by one shows up at the ports as a stream shifted by one position. A preamble that is one bit short, or an address whose bits land in the command field, makes the scoreboard compare fail at the first misplaced bit, within one handshake of the fault. Address and command registers that shift in the wrong direction, or that are loaded without the increment, corrupt the body. They are caught within 8 to 29 accepted bits, and the known 64-bit whistle packet also catches them as a whole. A tail that ends early or late moves the done pulse, and this is seen one cycle after the last expected bit.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_LEAD = 3'd1,
        PH_SYNC = 3'd2,
        PH_ADDR = 3'd3,
        PH_MARK = 3'd4,
        PH_CMD  = 3'd5,
        PH_TAIL = 3'd6
    } phase_e;

    // Order of packet sections; the tail returns to idle.
    function automatic phase_e phase_after(phase_e p);
        case (p)
            PH_LEAD: return PH_SYNC;
            PH_SYNC: return PH_ADDR;
            PH_ADDR: return PH_MARK;
            PH_MARK: return PH_CMD;
            PH_CMD:  return PH_TAIL;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pkt_phase_ctrl.sv
module pkt_phase_ctrl
    import pkt_framer_pkg::*;
#(
    parameter int LEAD_LEN = 15,
    parameter int TAIL_LEN = 10,
    parameter int ADDR_W   = 8,
    parameter int CMD_W    = 29
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   launch_i,
    input  logic   advance_i,
    output phase_e phase_o,
    output logic   finish_o
);

    localparam int MAX_A  = (LEAD_LEN > TAIL_LEN) ? LEAD_LEN : TAIL_LEN;
    localparam int MAX_B  = (ADDR_W > CMD_W) ? ADDR_W : CMD_W;
    localparam int MAXLEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAXLEN + 1);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        phase_e phase;
        cnt_t   cnt;
        logic   finish;
    } ctrl_t;

    ctrl_t st_d, st_q;

    function automatic cnt_t last_idx(phase_e p);
        case (p)
            PH_LEAD: return cnt_t'(LEAD_LEN - 1);
            PH_ADDR: return cnt_t'(ADDR_W - 1);
            PH_CMD:  return cnt_t'(CMD_W - 1);
            PH_TAIL: return cnt_t'(TAIL_LEN - 1);
            default: return cnt_t'(0);
        endcase
    endfunction

    always_comb begin
        st_d        = st_q;
        st_d.finish = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (launch_i) begin
                st_d.phase = PH_LEAD;
                st_d.cnt   = '0;
            end
        end else if (advance_i) begin
            if (st_q.cnt == last_idx(st_q.phase)) begin
                st_d.cnt   = '0;
                st_d.phase = phase_after(st_q.phase);
                if (st_q.phase == PH_TAIL) begin
                    st_d.finish = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + cnt_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, cnt: '0, finish: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign finish_o = st_q.finish;

    // R7
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= last_idx(st_q.phase));

    // R7
    tail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_TAIL && advance_i && st_q.cnt == last_idx(PH_TAIL))
        |=> (st_q.phase == PH_IDLE));

endmodule

// File: rtl/pkt_field_store.sv
module pkt_field_store #(
    parameter int ADDR_W = 8,
    parameter int CMD_W  = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] engine_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic              addr_shift_i,
    input  logic              cmd_shift_i,
    output logic              addr_bit_o,
    output logic              cmd_bit_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
    } fields_t;

    fields_t fl_d, fl_q;

    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    always_comb begin
        fl_d = fl_q;
        if (load_i) begin
            fl_d.addr = engine_i + ADDR_ONE;
            fl_d.cmd  = cmd_i;
        end else begin
            if (addr_shift_i) begin
                fl_d.addr = {1'b0, fl_q.addr[ADDR_W-1:1]};
            end
            if (cmd_shift_i) begin
                fl_d.cmd = {fl_q.cmd[CMD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign addr_bit_o = fl_q.addr[0];
    assign cmd_bit_o  = fl_q.cmd[CMD_W-1];

    // R9
    fields_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !addr_shift_i && !cmd_shift_i) |=> $stable(fl_q));

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter int LEAD_LEN = 15,
    parameter int TAIL_LEN = 10,
    parameter int ADDR_W   = 8,
    parameter int CMD_W    = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] engine_i,
    input  logic [CMD_W-1:0]  cmd_i,
    output logic              bit_valid_o,
    input  logic              bit_ready_i,
    output logic              bit_o,
    output logic              busy_o,
    output logic              done_o
);

    phase_e phase;
    logic   finish;
    logic   addr_bit, cmd_bit;
    logic   active, launch, accept;
    logic   bit_d;

    assign active = (phase != PH_IDLE);
    assign launch = start_i && !active;
    assign accept = active && bit_ready_i;

    pkt_phase_ctrl #(
        .LEAD_LEN(LEAD_LEN),
        .TAIL_LEN(TAIL_LEN),
        .ADDR_W  (ADDR_W),
        .CMD_W   (CMD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .advance_i(accept),
        .phase_o  (phase),
        .finish_o (finish)
    );

    pkt_field_store #(
        .ADDR_W(ADDR_W),
        .CMD_W (CMD_W)
    ) u_fields (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (launch),
        .engine_i    (engine_i),
        .cmd_i       (cmd_i),
        .addr_shift_i(accept && phase == PH_ADDR),
        .cmd_shift_i (accept && phase == PH_CMD),
        .addr_bit_o  (addr_bit),
        .cmd_bit_o   (cmd_bit)
    );

    always_comb begin
        case (phase)
            PH_SYNC: bit_d = 1'b0;
            PH_ADDR: bit_d = addr_bit;
            PH_CMD:  bit_d = cmd_bit;
            default: bit_d = 1'b1;
        endcase
    end

    assign bit_o       = bit_d;
    assign bit_valid_o = active;
    assign busy_o      = active;
    assign done_o      = finish;

    // R8
    hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid_o && !bit_ready_i) |=> (bit_valid_o && $stable(bit_o)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !bit_valid_o));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && bit_valid_o && bit_o));

    // R3
    lead_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> bit_o);

endmodule

// File: tb/tb_pkt_framer.sv
`timescale 1ns/1ps
module tb_pkt_framer;

    localparam int LEAD_LEN = 15;
    localparam int TAIL_LEN = 10;
    localparam int ADDR_W   = 8;
    localparam int CMD_W    = 29;
    localparam int TOTAL    = LEAD_LEN + 1 + ADDR_W + 1 + CMD_W + TAIL_LEN;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] engine_i = '0;
    logic [CMD_W-1:0]  cmd_i = '0;
    logic              bit_valid_o, bit_o, busy_o, done_o;
    logic              bit_ready_i = 1'b1;

    always #2 clk = ~clk;

    pkt_framer #(
        .LEAD_LEN(LEAD_LEN), .TAIL_LEN(TAIL_LEN), .ADDR_W(ADDR_W), .CMD_W(CMD_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .engine_i(engine_i),
        .cmd_i(cmd_i), .bit_valid_o(bit_valid_o), .bit_ready_i(bit_ready_i),
        .bit_o(bit_o), .busy_o(busy_o), .done_o(done_o)
    );

    typedef struct {
        logic  b;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    int tests_d = 0, fails_d = 0;
    int tests_m = 0, fails_m = 0;
    int ready_mode = 0;
    int golden_en = 0;
    logic [15:0] lfsr = 16'hACE1;

    localparam logic [63:0] WHISTLE_PKT =
        64'b1111111111111110010011001010000000000000010000000110001111111111;
    localparam logic [CMD_W-1:0] WHISTLE_CMD = 29'b01000000000000001000000011000;

    // Ready pattern, changed just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            case (ready_mode)
                0: bit_ready_i = 1'b1;
                1: bit_ready_i = lfsr[0] | lfsr[5];
                default: bit_ready_i = lfsr[2] & lfsr[7];
            endcase
        end
    end

    // Monitor / scoreboard
    logic        done_due = 1'b0;
    logic        hold_pend = 1'b0;
    logic        hold_bit = 1'b0;
    int          bits_rx = 0;
    logic [63:0] rx_vec = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            tests_m++;
            if (done_o !== done_due) begin
                fails_m++;
                $display("FAIL R10: done_o got %0b expected %0b", done_o, done_due);
            end
            if (done_due) begin
                tests_m++;
                if (busy_o !== 1'b0 || bit_valid_o !== 1'b0) begin
                    fails_m++;
                    $display("FAIL R10: busy/valid at done got %0b/%0b expected 0/0",
                             busy_o, bit_valid_o);
                end
                tests_m++;
                if (bits_rx != TOTAL) begin
                    fails_m++;
                    $display("FAIL R7: packet length got %0d expected %0d", bits_rx, TOTAL);
                end
                if (golden_en != 0) begin
                    tests_m++;
                    if (rx_vec !== WHISTLE_PKT) begin
                        fails_m++;
                        $display("FAIL R7: whole packet got %b expected %b", rx_vec, WHISTLE_PKT);
                    end
                end
                bits_rx = 0;
            end
            done_due = 1'b0;
            if (hold_pend) begin
                tests_m++;
                if (bit_valid_o !== 1'b1 || bit_o !== hold_bit) begin
                    fails_m++;
                    $display("FAIL R8: held offer got valid %0b bit %0b expected valid 1 bit %0b",
                             bit_valid_o, bit_o, hold_bit);
                end
            end
            hold_pend = bit_valid_o && !bit_ready_i;
            hold_bit  = bit_o;
            if (bit_valid_o && bit_ready_i) begin
                tests_m++;
                if (exp_q.size() == 0) begin
                    fails_m++;
                    $display("FAIL R7: extra bit got %0b expected none", bit_o);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (bit_o !== e.b) begin
                        fails_m++;
                        $display("FAIL %s: bit %0d got %0b expected %0b", e.tag, bits_rx, bit_o, e.b);
                    end
                    if (exp_q.size() == 0) done_due = 1'b1;
                end
                bits_rx++;
                rx_vec = {rx_vec[62:0], bit_o};
            end
        end
    end

    // Driver: pushes expected bits from the requirements, then launches
    task automatic send_pkt(input logic [ADDR_W-1:0] eng, input logic [CMD_W-1:0] cmd,
                            input bit poke);
        logic [ADDR_W-1:0] a;
        while (busy_o) @(negedge clk);
        for (int i = 0; i < LEAD_LEN; i++) exp_q.push_back('{b: 1'b1, tag: "R3"});
        exp_q.push_back('{b: 1'b0, tag: "R4"});
        a = eng + 8'd1;   // R5, R11: wraps at 8 bits
        for (int i = 0; i < ADDR_W; i++) exp_q.push_back('{b: a[i], tag: "R5"});
        exp_q.push_back('{b: 1'b1, tag: "R6"});
        for (int i = CMD_W - 1; i >= 0; i--) exp_q.push_back('{b: cmd[i], tag: "R6"});
        for (int i = 0; i < TAIL_LEN; i++) exp_q.push_back('{b: 1'b1, tag: "R7"});
        engine_i = eng;
        cmd_i    = cmd;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        engine_i = ~eng;   // R2: capture happened on the start edge
        cmd_i    = ~cmd;
        tests_d++;
        if (busy_o !== 1'b1 || bit_valid_o !== 1'b1) begin
            fails_d++;
            $display("FAIL R2: busy/valid after start got %0b/%0b expected 1/1", busy_o, bit_valid_o);
        end
        if (poke) begin
            // R9: start while busy must not restart or alter the packet
            repeat (6) @(negedge clk);
            engine_i = 8'h3C;
            cmd_i    = '1;
            start_i  = 1'b1;
            repeat (3) @(negedge clk);
            start_i  = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        tests_d++;
        if (busy_o !== 1'b0 || bit_valid_o !== 1'b0 || done_o !== 1'b0) begin
            fails_d++;
            $display("FAIL R1: in reset busy/valid/done got %0b/%0b/%0b expected 0/0/0",
                     busy_o, bit_valid_o, done_o);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        tests_d++;
        if (busy_o !== 1'b0 || bit_valid_o !== 1'b0 || done_o !== 1'b0) begin
            fails_d++;
            $display("FAIL R1: after reset busy/valid/done got %0b/%0b/%0b expected 0/0/0",
                     busy_o, bit_valid_o, done_o);
        end

        // R7: known whistle packet for engine 49
        golden_en = 1;
        send_pkt(8'd49, WHISTLE_CMD, 1'b0);
        golden_en = 0;

        // R8: stalls from downstream
        ready_mode = 1;
        send_pkt(8'd49, WHISTLE_CMD, 1'b0);
        ready_mode = 2;
        send_pkt(8'd7, 29'h15555555, 1'b0);

        // R9: start while busy
        send_pkt(8'd100, 29'h0ABCDEF1, 1'b1);
        ready_mode = 0;
        send_pkt(8'd0, 29'h1FFFFFFF, 1'b1);

        // R11: wrap of the address
        send_pkt(8'd255, 29'h00000001, 1'b0);
        ready_mode = 1;
        send_pkt(8'd254, 29'h10000000, 1'b0);

        // back-to-back launches
        ready_mode = 0;
        send_pkt(8'd128, 29'h00000000, 1'b0);
        send_pkt(8'd1, 29'h12345678, 1'b0);

        repeat (4) @(negedge clk);
        tests_d++;
        if (exp_q.size() != 0 || busy_o !== 1'b0) begin
            fails_d++;
            $display("FAIL R7: leftover bits got %0d expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests_d + tests_m, fails_d + fails_m);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL R10: watchdog expired, got no finish expected finish");
        $display("[TB] %0d tests run, %0d failed", tests_d + tests_m + 1, fails_d + fails_m + 1);
        $finish;
    end

endmodule